// File: doc/BRIEF.md
# Segmented Data Memory Address Extender

This block sits between a small 8-bit CPU core and its data RAM. Every data access carries an 8-bit address. The block turns it into a 16-bit physical address, using a segment register that the CPU reads and writes like any other data location. Addresses in the upper half of the 8-bit space (bit 7 set) are never extended. They always land on the fixed page 0x0080 to 0x00FF, which holds the I/O window, the register bytes and the segment register itself. Addresses in the lower half become `{segment, 0, addr[6:0]}`, so each segment value selects its own 128-byte slice of a 32 KB space.

Accesses made through the stack pointer are flagged by the CPU on `stack_i`. They always use segment 0 and never modify the segment register, so call, return and interrupt linkage stays in the base page whatever segment the program has selected.

Each access is classified as one of four targets:
- the local RAM model,
- the I/O and control window, which is served by an external register file,
- the segment register,
- an unpopulated hole.

Holes read as 0xFF and ignore writes. The physical address and the select outputs are combinational. Read data is registered and appears one clock after the read strobe.

Top module: `dmem_seg_mapper`

## Requirements
- R1: A synchronous reset sets the segment register to 0x00, and a read of address 0xFF after reset returns 0x00.
- R2: For an address with bit 7 = 1, `phys_o` equals `{8'h00, addr_i}` whatever the segment register and `stack_i` hold.
- R3: For a non-stack access with bit 7 = 0, `phys_o` equals `{seg, 1'b0, addr_i[6:0]}`.
- R4: A stack access (`stack_i` = 1) with bit 7 = 0 uses segment 0. A stack access never modifies the segment register: a stack write to 0xFF is ignored, and a stack read of 0xFF returns 0xFF.
- R5: A non-stack write to address 0xFF loads the segment register on that clock edge. The very next access is mapped with the new value. A non-stack read of 0xFF returns the register value.
- R6: `rdata_o` holds the data of a read in the clock cycle after the cycle in which `rd_i` was high.
- R7: Physical locations 0x0000 to 0x006F, 0x00F0 to 0x00FE and 0x0100 to 0x013F are RAM. A write stores the byte, and a later read returns it.
- R8: Every other physical location outside the I/O window, including 0x0070 to 0x007F, 0x0140 to 0x017F and segments 2 and above, reads as 0xFF. Writes to these locations are ignored.
- R9: An access to physical 0x0080 to 0x00EF raises `io_sel_o`. A read there returns `io_rdata_i` as sampled in the read cycle.
- R10: `ram_sel_o` is high exactly when a strobe is active and the target is RAM. `ram_sel_o` and `io_sel_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 8 | CPU data address |
| stack_i | input | 1 | 1 = stack-pointer access, 0 = direct or pointer access |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| io_rdata_i | input | 8 | Read data from the external register file |
| phys_o | output | 16 | Physical address (combinational) |
| ram_sel_o | output | 1 | Access targets local RAM |
| io_sel_o | output | 1 | Access targets the I/O window |
| rdata_o | output | 8 | Read data, one cycle after `rd_i` |
| seg_o | output | 8 | Current segment register value |

## Verification
The embedded properties watch the address mapping on every cycle:
- the upper-half bypass,
- segment 0 on stack accesses,
- the segment register held steady on stack accesses and when no write to it is made,
- 0xFF after a hole read,
- mutual exclusion of the two selects.

Only the bench's sweeps can show the following:
- that every populated RAM byte in segments 0 and 1 keeps what was written,
- that the hole map has exactly the right edges,
- that the I/O window forwards external data,
- that a segment write redirects the very next access.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  typedef enum logic [1:0] {
    TGT_RAM  = 2'd0,
    TGT_IO   = 2'd1,
    TGT_HOLE = 2'd2,
    TGT_SEG  = 2'd3
  } target_e;
endpackage

// File: rtl/dmx_decode.sv
module dmx_decode #(
  parameter int LOW_BYTES   = 112,
  parameter int REG_BASE    = 240,
  parameter int EXTRA_SEG   = 1,
  parameter int EXTRA_BYTES = 64,
  parameter int IDX_W       = 8
) (
  input  logic [7:0]       addr_i,
  input  logic             stack_i,
  input  logic [7:0]       seg_i,
  output logic [15:0]      phys_o,
  output dmx_pkg::target_e tgt_o,
  output logic [IDX_W-1:0] idx_o
);
  import dmx_pkg::*;

  localparam int REG_SPAN = 255 - REG_BASE;
  localparam logic [7:0] LOW_TOP   = 8'(LOW_BYTES);
  localparam logic [7:0] REG_LO    = 8'(REG_BASE);
  localparam logic [7:0] XSEG      = 8'(EXTRA_SEG);
  localparam logic [7:0] XTOP      = 8'(EXTRA_BYTES);
  localparam logic [IDX_W-1:0] REG_OFS = IDX_W'(LOW_BYTES);
  localparam logic [IDX_W-1:0] X_OFS   = IDX_W'(LOW_BYTES + REG_SPAN);

  logic       extend;
  logic [7:0] page;
  logic [7:0] low7;

  always_comb begin
    extend = !addr_i[7] && !stack_i;
    phys_o = addr_i[7] ? {8'h00, addr_i}
                       : {(extend ? seg_i : 8'h00), 1'b0, addr_i[6:0]};
    page   = phys_o[15:8];
    low7   = {1'b0, phys_o[6:0]};
    tgt_o  = TGT_HOLE;
    idx_o  = '0;
    if (page == 8'h00) begin
      if (!phys_o[7]) begin
        if (low7 < LOW_TOP) begin
          tgt_o = TGT_RAM;
          idx_o = IDX_W'(low7);
        end
      end else if (phys_o[7:0] == 8'hFF) begin
        tgt_o = stack_i ? TGT_HOLE : TGT_SEG;
      end else if (phys_o[7:0] >= REG_LO) begin
        tgt_o = TGT_RAM;
        idx_o = REG_OFS + IDX_W'(phys_o[7:0] - REG_LO);
      end else begin
        tgt_o = TGT_IO;
      end
    end else if (page == XSEG && low7 < XTOP) begin
      tgt_o = TGT_RAM;
      idx_o = X_OFS + IDX_W'(low7);
    end
  end
endmodule

// File: rtl/dmx_seg_reg.sv
module dmx_seg_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end

  // R5: the register moves only on a write aimed at it
  a_r5_seg_holds: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/dmx_ram.sv
module dmx_ram #(
  parameter int DEPTH = 192,
  parameter int AW    = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) q <= mem[idx];
  end
endmodule

// File: rtl/dmem_seg_mapper.sv
module dmem_seg_mapper #(
  parameter int LOW_BYTES   = 112,
  parameter int REG_BASE    = 240,
  parameter int EXTRA_SEG   = 1,
  parameter int EXTRA_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  addr_i,
  input  logic        stack_i,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic [7:0]  wdata_i,
  input  logic [7:0]  io_rdata_i,
  output logic [15:0] phys_o,
  output logic        ram_sel_o,
  output logic        io_sel_o,
  output logic [7:0]  rdata_o,
  output logic [7:0]  seg_o
);
  import dmx_pkg::*;

  localparam int DEPTH = LOW_BYTES + (255 - REG_BASE) + EXTRA_BYTES;
  localparam int IDX_W = $clog2(DEPTH);

  target_e          tgt;
  logic [IDX_W-1:0] idx;
  logic [7:0]       ram_q;
  logic             strobe;
  logic             from_ram_q;
  logic [7:0]       side_q;

  dmx_decode #(
    .LOW_BYTES(LOW_BYTES), .REG_BASE(REG_BASE), .EXTRA_SEG(EXTRA_SEG),
    .EXTRA_BYTES(EXTRA_BYTES), .IDX_W(IDX_W)
  ) u_dec (
    .addr_i(addr_i), .stack_i(stack_i), .seg_i(seg_o),
    .phys_o(phys_o), .tgt_o(tgt), .idx_o(idx)
  );

  dmx_seg_reg #(.W(8)) u_seg (
    .clk(clk), .rst(rst), .we(wr_i && tgt == TGT_SEG),
    .d(wdata_i), .q(seg_o)
  );

  dmx_ram #(.DEPTH(DEPTH), .AW(IDX_W), .DW(8)) u_ram (
    .clk(clk), .we(wr_i && tgt == TGT_RAM), .re(rd_i && tgt == TGT_RAM),
    .idx(idx), .wdata(wdata_i), .q(ram_q)
  );

  assign strobe    = rd_i || wr_i;
  assign ram_sel_o = strobe && tgt == TGT_RAM;
  assign io_sel_o  = strobe && tgt == TGT_IO;

  always_ff @(posedge clk) begin
    if (rst) begin
      from_ram_q <= 1'b0;
      side_q     <= 8'hFF;
    end else if (rd_i) begin
      from_ram_q <= (tgt == TGT_RAM);
      case (tgt)
        TGT_SEG: side_q <= seg_o;
        TGT_IO:  side_q <= io_rdata_i;
        default: side_q <= 8'hFF;
      endcase
    end
  end

  assign rdata_o = from_ram_q ? ram_q : side_q;

  // R2: upper half is never extended
  a_r2_upper_bypass: assert property (@(posedge clk) disable iff (rst)
    addr_i[7] |-> phys_o == {8'h00, addr_i});
  // R4: stack accesses stay in segment 0
  a_r4_stack_seg0: assert property (@(posedge clk) disable iff (rst)
    stack_i |-> phys_o[15:8] == 8'h00);
  // R4: stack accesses leave the segment register alone
  a_r4_stack_keeps_seg: assert property (@(posedge clk) disable iff (rst)
    stack_i |=> $stable(seg_o));
  // R8: hole reads return all ones
  a_r8_hole_ones: assert property (@(posedge clk) disable iff (rst)
    (rd_i && tgt == TGT_HOLE) |=> rdata_o == 8'hFF);
  // R10: at most one target select
  a_r10_sel_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_sel_o, io_sel_o}));
endmodule

// File: tb/dmem_seg_mapper_test.sv
module dmem_seg_mapper_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] addr_i = '0;
  logic stack_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] io_rdata_i;
  logic [15:0] phys_o;
  logic ram_sel_o, io_sel_o;
  logic [7:0] rdata_o, seg_o;
  int n_run = 0, n_fail = 0;

  assign io_rdata_i = ~addr_i;

  always #(CLK_P/2) clk = ~clk;

  dmem_seg_mapper uut (
    .clk(clk), .rst(rst), .addr_i(addr_i), .stack_i(stack_i), .rd_i(rd_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .io_rdata_i(io_rdata_i), .phys_o(phys_o),
    .ram_sel_o(ram_sel_o), .io_sel_o(io_sel_o), .rdata_o(rdata_o), .seg_o(seg_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_phys(logic [7:0] a, bit stk, logic [7:0] s);
    if (a[7]) return {8'h00, a};
    return {(stk ? 8'h00 : s), 1'b0, a[6:0]};
  endfunction

  // 0 ram, 1 io, 2 hole, 3 segment register
  function automatic int kind(logic [15:0] p, bit stk);
    if (p == 16'h00FF) return stk ? 2 : 3;
    if (p < 16'h0070) return 0;
    if (p < 16'h0080) return 2;
    if (p < 16'h00F0) return 1;
    if (p < 16'h0100) return 0;
    if (p < 16'h0140) return 0;
    return 2;
  endfunction

  function automatic logic [7:0] pat(logic [15:0] p);
    return p[7:0] ^ (p[15:8] * 8'd37) ^ 8'h5A;
  endfunction

  task automatic wr(input logic [7:0] a, input bit stk, input logic [7:0] d,
                    input logic [7:0] s);
    logic [15:0] p;
    @(negedge clk);
    addr_i = a; stack_i = stk; wr_i = 1'b1; wdata_i = d;
    #1;
    p = exp_phys(a, stk, s);
    chk(phys_o == p, a[7] ? "R2 phys" : (stk ? "R4 phys" : "R3 phys"), phys_o, p);
    chk(ram_sel_o == (kind(p, stk) == 0), "R10 ram_sel", ram_sel_o, kind(p, stk) == 0);
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input bit stk, input logic [7:0] exp,
                    input logic [7:0] s, input string req);
    logic [15:0] p;
    @(negedge clk);
    addr_i = a; stack_i = stk; rd_i = 1'b1;
    #1;
    p = exp_phys(a, stk, s);
    chk(phys_o == p, a[7] ? "R2 phys" : (stk ? "R4 phys" : "R3 phys"), phys_o, p);
    chk(ram_sel_o == (kind(p, stk) == 0), "R10 ram_sel", ram_sel_o, kind(p, stk) == 0);
    chk(io_sel_o == (kind(p, stk) == 1), "R9 io_sel", io_sel_o, kind(p, stk) == 1);
    @(negedge clk);
    rd_i = 1'b0;
    chk(rdata_o == exp, req, rdata_o, exp);
  endtask

  function automatic logic [7:0] exp_read(logic [15:0] p, logic [7:0] a, logic [7:0] s);
    case (kind(p, 1'b0))
      0: return pat(p);
      1: return ~a;
      3: return s;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic string tag(logic [15:0] p);
    case (kind(p, 1'b0))
      0: return "R7 ram data";
      1: return "R9 io data";
      3: return "R5 seg read";
      default: return "R8 hole";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    chk(seg_o == 8'h00, "R1 reset seg", seg_o, 0);
    rd(8'hFF, 1'b0, 8'h00, 8'h00, "R1 read seg after reset");

    // write sweep over segments 0..3
    for (int s = 0; s < 4; s++) begin
      wr(8'hFF, 1'b0, 8'(s), 8'(s));
      chk(seg_o == 8'(s), "R5 seg write", seg_o, s);
      for (int a = 0; a < 255; a++)
        wr(8'(a), 1'b0, pat(exp_phys(8'(a), 1'b0, 8'(s))), 8'(s));
    end

    // read-back sweep (R6 timing checked by every read)
    for (int s = 0; s < 4; s++) begin
      wr(8'hFF, 1'b0, 8'(s), 8'(s));
      for (int a = 0; a < 256; a++) begin
        logic [15:0] p;
        p = exp_phys(8'(a), 1'b0, 8'(s));
        rd(8'(a), 1'b0, exp_read(p, 8'(a), 8'(s)), 8'(s), tag(p));
      end
    end

    // stack accesses with segment 3 selected
    wr(8'hFF, 1'b0, 8'h03, 8'h03);
    rd(8'h10, 1'b1, pat(16'h0010), 8'h03, "R4 stack read seg0");
    wr(8'h20, 1'b1, 8'hA5, 8'h03);
    wr(8'hFF, 1'b1, 8'h77, 8'h03);
    chk(seg_o == 8'h03, "R4 stack write keeps seg", seg_o, 3);
    rd(8'hFF, 1'b1, 8'hFF, 8'h03, "R4 stack read of FF");
    wr(8'hFF, 1'b0, 8'h00, 8'h00);
    rd(8'h20, 1'b0, 8'hA5, 8'h00, "R4 stack write landed seg0");

    // segment change steers the very next access
    wr(8'hFF, 1'b0, 8'h01, 8'h01);
    rd(8'h05, 1'b0, pat(16'h0105), 8'h01, "R5 next access uses new seg");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule